// File: doc/BRIEF.md
# Boot Memory Remap and Alias Decoder

This block turns a processor address into a chip-select and a local offset for one of two memories: a boot Flash and a static RAM. Two run-time control bits reshape the address map. The remap bit places the static RAM over the bottom of the map, hiding the Flash there. Software can then rewrite the vector table, and boot code can run from RAM. The alias bit opens a second window onto the whole Flash inside the RAM address space. Through this window the Flash stays fully reachable, including while remap is on, and it can be reprogrammed there.

The control bits live in one configuration register behind a plain word-wide register port: a write strobe with write data, and a read-data output that is always valid. A third bit of that register selects the debug-port flavour and is driven straight out of the block. Decode is purely combinational from the address and the registered configuration. The `acc_valid` qualifier has no back-pressure: the decode answers in the same cycle and no ready signal exists. A request with no matching region raises `dec_err` instead of a select.

Top module: `bootmap_decoder`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x0000_0002. This means remap (bit 0) is 0, alias (bit 1) is 1 and debug select (bit 2) is 0, so `dbg_swd` is 0.
- R2: A cycle with `cfg_wr`=1 stores `cfg_wdata[2:0]`. Bits 31:3 of `cfg_rdata` always read 0, whatever was written.
- R3: `dbg_swd` always equals configuration bit 2. The value 1 selects serial-wire debug and 0 selects JTAG.
- R4: With remap=0 and alias=0, an address in [0x0000_0000, 0x0080_0000) asserts `flash_cs`, and `mem_offset` is the address. An address in [0x2000_0000, 0x2100_0000) asserts `ram_cs`, and `mem_offset` is the address minus 0x2000_0000.
- R5: With remap=1, an address in [0x0000_0000, 0x0040_0000) asserts `ram_cs` with `mem_offset` equal to the address. Flash at [0x0040_0000, 0x0080_0000) is still decoded as in R4.
- R6: With alias=1, an address in [0x2040_0000, 0x20C0_0000) asserts `flash_cs` with `mem_offset` equal to the address minus 0x2040_0000. This window takes priority over the RAM decode and works whatever the remap setting.
- R7: With `acc_valid`=1, an address outside every enabled region asserts `dec_err` with `mem_offset`=0. At most one of `flash_cs`, `ram_cs` and `dec_err` is high at any time.
- R8: With `acc_valid`=0, `flash_cs`, `ram_cs` and `dec_err` are all 0.
- R9: In the cycle of a write, decode still uses the old configuration. The new value governs decode from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| dbg_swd | output | 1 | Debug-port select (1 serial-wire, 0 JTAG) |
| acc_valid | input | 1 | Address qualifier |
| acc_addr | input | 32 | Processor address |
| flash_cs | output | 1 | Flash chip-select |
| ram_cs | output | 1 | Static RAM chip-select |
| mem_offset | output | 24 | Offset within the selected memory |
| dec_err | output | 1 | No region matched |

## Verification
The hardest case to reach is one where the alias window and the remap overlay both apply. The alias window must override the RAM there, while the overlay hides only the lower half of the Flash. The error must also fire exactly one byte past each window edge. The bench drives all four remap and alias settings through register writes. In each setting it sends a directed list of the first and last byte of every region, plus their outside neighbours, then random addresses drawn mostly near those edges. A write followed at once by a decode in the same cycle shows when a new setting takes effect.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
  // Decode regions, in descending priority
  localparam int NREG = 4;
  localparam int REG_ALIAS   = 0;
  localparam int REG_OVERLAY = 1;
  localparam int REG_FLASH   = 2;
  localparam int REG_RAM     = 3;

  typedef struct packed {
    logic swd;
    logic alias_on;
    logic remap;
  } boot_cfg_t;

  localparam boot_cfg_t CFG_RESET = '{swd: 1'b0, alias_on: 1'b1, remap: 1'b0};
endpackage

// File: rtl/bootmap_cfg_reg.sv
module bootmap_cfg_reg
  import bootmap_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output boot_cfg_t     cfg
);
  localparam int CW = $bits(boot_cfg_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg <= CFG_RESET;
    else if (wr) cfg <= boot_cfg_t'(wdata[CW-1:0]);
  end

  assign rdata = {{(DW-CW){1'b0}}, cfg};

  // R2: reserved bits stay zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:CW] == '0);
  // R9: register only moves on a write
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cfg));
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> rdata[CW-1:0] == $past(wdata[CW-1:0]));
endmodule

// File: rtl/bootmap_window.sv
module bootmap_window #(
  parameter int              AW   = 32,
  parameter int              OW   = 24,
  parameter longint unsigned BASE = 0,
  parameter longint unsigned SIZE = 1
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [OW-1:0] offset
);
  logic [63:0] wide, diff;

  always_comb begin
    wide   = 64'(addr);
    diff   = wide - BASE;
    hit    = (wide >= BASE) && (diff < SIZE);
    offset = diff[OW-1:0];
  end
endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
  import bootmap_pkg::*;
#(
  parameter int              ADDR_W       = 32,
  parameter int              DATA_W       = 32,
  parameter longint unsigned FLASH_BASE   = 64'h0000_0000,
  parameter longint unsigned FLASH_SIZE   = 64'h0080_0000,
  parameter longint unsigned RAM_BASE     = 64'h2000_0000,
  parameter longint unsigned RAM_SIZE     = 64'h0100_0000,
  parameter longint unsigned OVERLAY_SIZE = 64'h0040_0000,
  parameter longint unsigned ALIAS_OFFS   = 64'h0040_0000,
  localparam longint unsigned MAX_SIZE = (FLASH_SIZE > RAM_SIZE) ? FLASH_SIZE : RAM_SIZE,
  localparam int              OFF_W    = $clog2(MAX_SIZE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              dbg_swd,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              flash_cs,
  output logic              ram_cs,
  output logic [OFF_W-1:0]  mem_offset,
  output logic              dec_err
);
  localparam longint unsigned ALIAS_BASE = RAM_BASE + ALIAS_OFFS;
  localparam longint unsigned WBASE [NREG] = '{ALIAS_BASE, FLASH_BASE, FLASH_BASE, RAM_BASE};
  localparam longint unsigned WSIZE [NREG] = '{FLASH_SIZE, OVERLAY_SIZE, FLASH_SIZE, RAM_SIZE};
  // 1 = region targets the RAM, 0 = the Flash
  localparam logic [NREG-1:0] TO_RAM = 4'b1010;

  boot_cfg_t cfg;

  bootmap_cfg_reg #(.DW(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg)
  );

  assign dbg_swd = cfg.swd;

  logic [NREG-1:0]  hit;
  logic [OFF_W-1:0] woff [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_win
    bootmap_window #(.AW(ADDR_W), .OW(OFF_W), .BASE(WBASE[g]), .SIZE(WSIZE[g])) u_win (
      .addr(acc_addr), .hit(hit[g]), .offset(woff[g])
    );
  end

  logic [NREG-1:0] en;
  assign en = {1'b1, 1'b1, cfg.remap, cfg.alias_on};

  always_comb begin
    flash_cs   = 1'b0;
    ram_cs     = 1'b0;
    dec_err    = 1'b0;
    mem_offset = '0;
    if (acc_valid) begin
      dec_err = 1'b1;
      for (int i = NREG - 1; i >= 0; i--) begin
        if (en[i] && hit[i]) begin
          dec_err    = 1'b0;
          flash_cs   = !TO_RAM[i];
          ram_cs     = TO_RAM[i];
          mem_offset = woff[i];
        end
      end
    end
  end

  // R7: exclusive outcome
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flash_cs, ram_cs, dec_err}));
  // R8: idle bus selects nothing
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !(flash_cs || ram_cs || dec_err));
  // R3: debug select follows the register
  a_r3_dbg_follows: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_swd == cfg_rdata[2]);
  // R6: alias window always reaches the Flash
  a_r6_alias_flash: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cfg.alias_on && hit[REG_ALIAS]) |-> flash_cs);
  // R5: overlay always reaches the RAM
  a_r5_overlay_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cfg.remap && hit[REG_OVERLAY] && !(cfg.alias_on && hit[REG_ALIAS])) |-> ram_cs);
  // R7: error carries a zero offset
  a_r7_err_offset: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> mem_offset == '0);
endmodule

// File: tb/bootmap_decoder_bench.sv
module bootmap_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RAMB = 32'h2000_0000;
  localparam logic [31:0] ALB  = 32'h2040_0000;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, acc_valid = 0, dbg_swd, flash_cs, ram_cs, dec_err;
  logic [31:0] cfg_wdata = 0, cfg_rdata, acc_addr = 0;
  logic [23:0] mem_offset;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bootmap_decoder u_bootmap_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dbg_swd(dbg_swd), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .flash_cs(flash_cs), .ram_cs(ram_cs),
    .mem_offset(mem_offset), .dec_err(dec_err)
  );

  // expected {flash_cs, ram_cs, dec_err, offset}
  function automatic logic [26:0] ref_map(logic [31:0] a, bit remap, bit aln, bit v);
    if (!v) return '0;
    if (aln && a >= ALB && a < ALB + 32'h80_0000) return {3'b100, 24'(a - ALB)};
    if (remap && a < 32'h40_0000)                return {3'b010, a[23:0]};
    if (a < 32'h80_0000)                         return {3'b100, a[23:0]};
    if (a >= RAMB && a < RAMB + 32'h100_0000)    return {3'b010, 24'(a - RAMB)};
    return {3'b001, 24'h0};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string map_req(logic [31:0] a, bit remap, bit aln);
    if (aln && a >= ALB && a < ALB + 32'h80_0000) return "R6";
    if (remap && a < 32'h40_0000) return "R5";
    if (a < 32'h80_0000 || (a >= RAMB && a < RAMB + 32'h100_0000)) return "R4";
    return "R7";
  endfunction

  task automatic probe(logic [31:0] a, bit remap, bit aln, bit v);
    acc_addr = a; acc_valid = v;
    #1;
    check(v ? map_req(a, remap, aln) : "R8",
          64'({flash_cs, ram_cs, dec_err, mem_offset}), 64'(ref_map(a, remap, aln, v)));
  endtask

  task automatic write_cfg(logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  logic [31:0] edges [26] = '{
    32'h0, 32'h1, 32'h3F_FFFF, 32'h40_0000, 32'h7F_FFFF, 32'h80_0000,
    32'h1FFF_FFFF, RAMB, RAMB + 1, ALB - 1, ALB, ALB + 32'h7F_FFFF,
    ALB + 32'h80_0000, RAMB + 32'hFF_FFFF, RAMB + 32'h100_0000,
    32'hFFFF_FFFF, 32'h1000_0000, 32'h40_0001, 32'h20_1234, ALB + 32'h12_3456,
    RAMB + 32'h3F_FFFF, RAMB + 32'hBF_FFFF, RAMB + 32'hC0_0000, 32'h8000_0000,
    32'h3F_FFFE, 32'h7F_FFFE};

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", 64'(cfg_rdata), 64'h2);
    check("R1", 64'(dbg_swd), 0);
    rst_n = 1;
    @(negedge clk);
    probe(32'h10, 0, 1, 0);
    for (int c = 0; c < 4; c++) begin
      bit rm = c[0], al = c[1];
      write_cfg({29'h1FFF_FFFF, 1'b0, al, rm});
      check("R2", 64'(cfg_rdata), 64'({al, rm}));
      for (int i = 0; i < 26; i++) probe(edges[i], rm, al, 1);
      for (int i = 0; i < 300; i++) begin
        logic [31:0] a;
        logic [31:0] r = $urandom;
        a = edges[r % 26] + 32'($signed(r[31:28])) - 8;
        if (r[27:26] == 0) a = $urandom;
        probe(a, rm, al, r[25:24] != 0);
        @(negedge clk);
      end
    end
    // R3 debug select bit
    write_cfg(32'h4);
    check("R3", 64'(dbg_swd), 1);
    check("R2", 64'(cfg_rdata), 64'h4);
    write_cfg(32'h3);
    check("R3", 64'(dbg_swd), 0);
    // R9 timing: now remap=1 alias=1; write remap=0 alias=0, probe in write cycle
    @(negedge clk);
    cfg_wr = 1; cfg_wdata = 32'h0;
    probe(32'h10, 1, 1, 1);
    check("R9", 64'(ram_cs), 1);
    probe(ALB + 32'h4, 1, 1, 1);
    check("R9", 64'(flash_cs), 1);
    @(negedge clk); cfg_wr = 0;
    probe(32'h10, 0, 0, 1);
    check("R9", 64'(flash_cs), 1);
    probe(ALB + 32'h4, 0, 0, 1);
    check("R9", 64'(ram_cs), 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule